// File: doc/BRIEF.md
# Event Capture Timer Channel

This block is one timer channel configured to measure the timing of external events. A 16-bit counter advances on tick strobes taken from one of several tick sources, and two asynchronous event pins, A and B, are brought into the clock domain through a two-stage synchronizer. Chosen transitions of pin A copy the running count into two capture holding registers. The first copy goes into capture A and the next into capture B. A selectable transition on either pin, or a software pulse, restarts the count from zero. The channel can also wrap the count back to zero when it reaches a programmable compare value.

Each event sets a sticky flag in a status word: a load into either capture register, a load that overwrote a value nobody read, a compare hit, a counter wrap and an external trigger. The status word also carries the run state and the synchronized levels of both pins. Reading the status word clears the event flags. A single interrupt line is raised when any flag that is enabled in the mask is set. Software can make a capture B load either freeze the count or turn the channel's clock off, so that a pulse width or a period is held for reading.

Top module: `tc_capture_channel`

## Requirements
- R1: During and after synchronous reset, count, both captures, the status word and irq are all zero, and the channel is not running.
- R2: While running and not frozen, the count increases by one in every cycle in which tick_src[clk_sel] is high. A clk_en_cmd pulse starts the channel and a clk_dis_cmd pulse stops it. When both arrive in the same cycle, the stop takes effect.
- R3: Pin transitions act three clock edges after the pin changes: two synchronizer stages, then the register update. A pin A transition that matches ld_a_edge (0 none, 1 rising, 2 falling, 3 both) copies the present count into cap_a, provided no capture A is pending its B partner. The load sets status bit 5.
- R4: A pin A transition that matches ld_b_edge (same encoding) loads cap_b only when capture A has been loaded since the last trigger or the last B load. Only one of the two loads can happen per event. The B load sets status bit 6.
- R5: A B load with stop_on_b set freezes the count until the next trigger. A B load with off_on_b set clears the run state, which is reported in status bit 16.
- R6: A pin transition that matches trg_edge (same encoding) triggers the channel. The pin is A when trg_from_a is 1 and B when it is 0. A trigger, or a sw_trig pulse, clears the count, releases a freeze and resets the A-then-B order, and no capture happens in that cycle. Only the pin trigger sets status bit 7.
- R7: A counting cycle in which the count equals rc_val sets status bit 4. With rc_restart_en set, the count goes to zero in that cycle instead of incrementing.
- R8: A counting cycle that moves the count from all ones to zero sets status bit 0.
- R9: A load into a capture register whose previous value is still unread sets status bit 1. A rd_a or rd_b pulse marks that register as read.
- R10: A rd_status pulse clears status bits 0 to 7. An event in the same cycle still sets its bit. Bits 2, 3 and 8 to 15 are always zero.
- R11: irq is high exactly when some status bit in 0 to 7 is set together with the matching irq_mask bit. Status bits 17 and 18 mirror the synchronized levels of pins A and B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_src | input | NSRC | Candidate count tick strobes |
| clk_sel | input | SEL_W | Index of the tick strobe in use |
| clk_en_cmd | input | 1 | Pulse: start the channel |
| clk_dis_cmd | input | 1 | Pulse: stop the channel |
| sw_trig | input | 1 | Pulse: software trigger |
| pin_a | input | 1 | Asynchronous event pin A |
| pin_b | input | 1 | Asynchronous event pin B |
| ld_a_edge | input | 2 | Pin A transition that loads cap_a |
| ld_b_edge | input | 2 | Pin A transition that loads cap_b |
| stop_on_b | input | 1 | Freeze the count on a B load |
| off_on_b | input | 1 | Stop the channel on a B load |
| trg_edge | input | 2 | Trigger transition |
| trg_from_a | input | 1 | Trigger pin: 1 = A, 0 = B |
| rc_restart_en | input | 1 | Restart the count on a compare hit |
| rc_val | input | CNT_W | Compare value |
| rd_a | input | 1 | Pulse: cap_a has been read |
| rd_b | input | 1 | Pulse: cap_b has been read |
| rd_status | input | 1 | Pulse: status has been read |
| irq_mask | input | 8 | Interrupt enable per status bit 0 to 7 |
| count | output | CNT_W | Current count |
| cap_a | output | CNT_W | Capture register A |
| cap_b | output | CNT_W | Capture register B |
| status | output | 19 | Event flags, run state and pin mirrors |
| irq | output | 1 | Masked interrupt |

## Verification
The bench builds the channel with an 8-bit counter and two tick sources. With that width a natural wrap from all ones to zero takes only 256 ticks, so the overflow flag and the case where the compare value and the wrap coincide can be reached in a short run. The second tick source pulses every third cycle, which shows that the selector gates counting rather than the clock.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_ANY  = 2'd3
    } edge_sel_e;

    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } pin_ev_t;

    localparam int ST_WRAP    = 0;
    localparam int ST_OVERRUN = 1;
    localparam int ST_CMP     = 4;
    localparam int ST_LOAD_A  = 5;
    localparam int ST_LOAD_B  = 6;
    localparam int ST_EXTTRG  = 7;
    localparam int ST_RUN     = 16;
    localparam int ST_PIN_A   = 17;
    localparam int ST_PIN_B   = 18;
    localparam int ST_W       = 19;
    localparam int FLAG_W     = 8;

    function automatic logic edge_match(edge_sel_e sel, pin_ev_t ev);
        case (sel)
            EDGE_RISE: return ev.rise;
            EDGE_FALL: return ev.fall;
            EDGE_ANY:  return ev.rise | ev.fall;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/tcc_pin_sync.sv
module tcc_pin_sync
    import tcc_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    pin,
    output pin_ev_t ev
);
    // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-1:0], pin};
    end

    always_comb begin
        ev.level = chain[STAGES-1];
        ev.rise  = chain[STAGES-1] & ~chain[STAGES];
        ev.fall  = ~chain[STAGES-1] & chain[STAGES];
    end
endmodule

// File: rtl/tcc_counter.sv
module tcc_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         en_cmd,
    input  logic         dis_cmd,
    input  logic         hard_trig,
    input  logic         rc_restart_en,
    input  logic [W-1:0] rc_val,
    input  logic         freeze_req,
    input  logic         off_req,
    output logic [W-1:0] count,
    output logic         running,
    output logic         adv,
    output logic         restart,
    output logic         cmp_hit,
    output logic         wrap
);
    localparam logic [W-1:0] TOP = '1;

    logic frozen;

    always_comb begin
        adv     = running & ~frozen & tick;
        cmp_hit = adv & (count == rc_val);
        restart = hard_trig | (rc_restart_en & cmp_hit);
        wrap    = adv & ~restart & (count == TOP);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count   <= '0;
            running <= 1'b0;
            frozen  <= 1'b0;
        end else begin
            if (restart)  count <= '0;
            else if (adv) count <= count + 1'b1;

            if (dis_cmd | off_req) running <= 1'b0;
            else if (en_cmd)       running <= 1'b1;

            if (hard_trig)       frozen <= 1'b0;
            else if (freeze_req) frozen <= 1'b1;
        end
    end
endmodule

// File: rtl/tcc_capture.sv
module tcc_capture
    import tcc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] count,
    input  pin_ev_t      ev_a,
    input  edge_sel_e    sel_a,
    input  edge_sel_e    sel_b,
    input  logic         hard_trig,
    input  logic         rd_a,
    input  logic         rd_b,
    output logic [W-1:0] cap_a,
    output logic [W-1:0] cap_b,
    output logic         load_a,
    output logic         load_b,
    output logic         overrun,
    output logic         armed_b
);
    logic unread_a, unread_b;

    always_comb begin
        load_a  = edge_match(sel_a, ev_a) & ~armed_b & ~hard_trig;
        load_b  = edge_match(sel_b, ev_a) &  armed_b & ~hard_trig;
        overrun = (load_a & unread_a & ~rd_a) | (load_b & unread_b & ~rd_b);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_a    <= '0;
            cap_b    <= '0;
            unread_a <= 1'b0;
            unread_b <= 1'b0;
            armed_b  <= 1'b0;
        end else begin
            if (load_a) cap_a <= count;
            if (load_b) cap_b <= count;
            unread_a <= load_a | (unread_a & ~rd_a);
            unread_b <= load_b | (unread_b & ~rd_b);
            if (hard_trig)   armed_b <= 1'b0;
            else if (load_a) armed_b <= 1'b1;
            else if (load_b) armed_b <= 1'b0;
        end
    end
endmodule

// File: rtl/tc_capture_channel.sv
module tc_capture_channel
    import tcc_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int NSRC   = 4,
    parameter int SYNC_N = 2,
    localparam int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  tick_src,
    input  logic [SEL_W-1:0] clk_sel,
    input  logic             clk_en_cmd,
    input  logic             clk_dis_cmd,
    input  logic             sw_trig,
    input  logic             pin_a,
    input  logic             pin_b,
    input  logic [1:0]       ld_a_edge,
    input  logic [1:0]       ld_b_edge,
    input  logic             stop_on_b,
    input  logic             off_on_b,
    input  logic [1:0]       trg_edge,
    input  logic             trg_from_a,
    input  logic             rc_restart_en,
    input  logic [CNT_W-1:0] rc_val,
    input  logic             rd_a,
    input  logic             rd_b,
    input  logic             rd_status,
    input  logic [7:0]       irq_mask,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] cap_a,
    output logic [CNT_W-1:0] cap_b,
    output logic [ST_W-1:0]  status,
    output logic             irq
);
    localparam int NPIN = 2;

    logic [NPIN-1:0] pins;
    pin_ev_t         pev [NPIN];

    assign pins = {pin_b, pin_a};

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        tcc_pin_sync #(.STAGES(SYNC_N)) u_sync (
            .clk (clk),
            .rst (rst),
            .pin (pins[p]),
            .ev  (pev[p])
        );
    end

    logic tick, ext_hit, hard_trig;
    logic running, adv, restart, cmp_hit, wrap;
    logic load_a, load_b, overrun, armed_b;
    logic [FLAG_W-1:0] flags, events;

    always_comb begin
        tick      = (32'(clk_sel) < NSRC) ? tick_src[clk_sel] : 1'b0;
        ext_hit   = edge_match(edge_sel_e'(trg_edge), trg_from_a ? pev[0] : pev[1]);
        hard_trig = ext_hit | sw_trig;
    end

    tcc_counter #(.W(CNT_W)) u_cnt (
        .clk           (clk),
        .rst           (rst),
        .tick          (tick),
        .en_cmd        (clk_en_cmd),
        .dis_cmd       (clk_dis_cmd),
        .hard_trig     (hard_trig),
        .rc_restart_en (rc_restart_en),
        .rc_val        (rc_val),
        .freeze_req    (load_b & stop_on_b),
        .off_req       (load_b & off_on_b),
        .count         (count),
        .running       (running),
        .adv           (adv),
        .restart       (restart),
        .cmp_hit       (cmp_hit),
        .wrap          (wrap)
    );

    tcc_capture #(.W(CNT_W)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .count     (count),
        .ev_a      (pev[0]),
        .sel_a     (edge_sel_e'(ld_a_edge)),
        .sel_b     (edge_sel_e'(ld_b_edge)),
        .hard_trig (hard_trig),
        .rd_a      (rd_a),
        .rd_b      (rd_b),
        .cap_a     (cap_a),
        .cap_b     (cap_b),
        .load_a    (load_a),
        .load_b    (load_b),
        .overrun   (overrun),
        .armed_b   (armed_b)
    );

    always_comb begin
        events             = '0;
        events[ST_WRAP]    = wrap;
        events[ST_OVERRUN] = overrun;
        events[ST_CMP]     = cmp_hit;
        events[ST_LOAD_A]  = load_a;
        events[ST_LOAD_B]  = load_b;
        events[ST_EXTTRG]  = ext_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= (rd_status ? '0 : flags) | events;
    end

    always_comb begin
        status                      = '0;
        status[FLAG_W-1:0]          = flags;
        status[ST_RUN]              = running;
        status[ST_PIN_A]            = pev[0].level;
        status[ST_PIN_B]            = pev[1].level;
        irq                         = |(flags & irq_mask);
    end
endmodule

// File: rtl/tcc_checker.sv
module tcc_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         clk_dis_cmd,
    input logic [W-1:0] count,
    input logic [18:0]  status,
    input logic [W-1:0] cap_b,
    input logic         armed_b,
    input logic         hard_trig,
    input logic         adv,
    input logic         restart
);
    // R1: first cycle after reset shows an idle channel
    a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (count == '0 && !status[16]));

    // R2: a stop command always leaves the channel stopped
    a_r2_disable_wins: assert property (@(posedge clk) disable iff (rst)
        clk_dis_cmd |=> !status[16]);

    // R4: capture B only changes while the A-then-B order is armed
    a_r4_b_after_a: assert property (@(posedge clk) disable iff (rst)
        !$stable(cap_b) |-> $past(armed_b));

    // R6: a trigger zeroes the count on the next edge
    a_r6_trigger_clears: assert property (@(posedge clk) disable iff (rst)
        hard_trig |=> count == '0);

    // R8: a natural wrap from all ones raises the wrap flag
    a_r8_wrap_flag: assert property (@(posedge clk) disable iff (rst)
        (adv && !restart && count == '1) |=> status[0]);
endmodule

bind tc_capture_channel tcc_checker #(.W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .clk_dis_cmd (clk_dis_cmd),
    .count       (count),
    .status      (status),
    .cap_b       (cap_b),
    .armed_b     (armed_b),
    .hard_trig   (hard_trig),
    .adv         (adv),
    .restart     (restart)
);

// File: tb/tb_tc_capture_channel.sv
module tb_tc_capture_channel;
    localparam int W  = 8;
    localparam int NS = 2;
    localparam bit [W-1:0] TOPV = '1;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst = 1'b1;
    logic [NS-1:0] tick_src = '0;
    logic [0:0] clk_sel = '0;
    logic clk_en_cmd = 0, clk_dis_cmd = 0, sw_trig = 0, pin_a = 0, pin_b = 0;
    logic [1:0] ld_a_edge = 0, ld_b_edge = 0, trg_edge = 0;
    logic stop_on_b = 0, off_on_b = 0, trg_from_a = 0, rc_restart_en = 0;
    logic [W-1:0] rc_val = 8'd200;
    logic rd_a = 0, rd_b = 0, rd_status = 0;
    logic [7:0] irq_mask = '0;
    logic [W-1:0] count, cap_a, cap_b;
    logic [18:0] status;
    logic irq;

    tc_capture_channel #(.CNT_W(W), .NSRC(NS)) dut (
        .clk(clk), .rst(rst), .tick_src(tick_src), .clk_sel(clk_sel),
        .clk_en_cmd(clk_en_cmd), .clk_dis_cmd(clk_dis_cmd), .sw_trig(sw_trig),
        .pin_a(pin_a), .pin_b(pin_b), .ld_a_edge(ld_a_edge), .ld_b_edge(ld_b_edge),
        .stop_on_b(stop_on_b), .off_on_b(off_on_b), .trg_edge(trg_edge),
        .trg_from_a(trg_from_a), .rc_restart_en(rc_restart_en), .rc_val(rc_val),
        .rd_a(rd_a), .rd_b(rd_b), .rd_status(rd_status), .irq_mask(irq_mask),
        .count(count), .cap_a(cap_a), .cap_b(cap_b), .status(status), .irq(irq)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // tick sources: source 0 every cycle, source 1 every third cycle
    int tcount = 0;
    always @(negedge clk) begin
        tcount++;
        tick_src[0] <= 1'b1;
        tick_src[1] <= (tcount % 3 == 0);
    end

    // ---------------- behavioural reference model ----------------
    int m_cnt;
    bit m_run, m_halt, m_arm, m_pa, m_pb;
    int m_ca, m_cb;
    bit [7:0] m_fl;
    bit [2:0] sa, sb;

    function automatic bit hit(bit [1:0] s, bit r, bit f);
        return (s == 2'd1 && r) || (s == 2'd2 && f) || (s == 2'd3 && (r || f));
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_run = 0; m_halt = 0; m_arm = 0; m_pa = 0; m_pb = 0;
            m_ca = 0; m_cb = 0; m_fl = 0; sa = 0; sb = 0;
        end else begin
            bit ra, fa, rb, fb, ext, ht, adv, rch, rs, ov, la, lb, ovr;
            bit [7:0] ev;
            ra = sa[1] && !sa[2]; fa = !sa[1] && sa[2];
            rb = sb[1] && !sb[2]; fb = !sb[1] && sb[2];
            ext = trg_from_a ? hit(trg_edge, ra, fa) : hit(trg_edge, rb, fb);
            ht  = ext || sw_trig;
            adv = m_run && !m_halt && tick_src[clk_sel];
            rch = adv && (m_cnt == int'(rc_val));
            rs  = ht || (rc_restart_en && rch);
            ov  = adv && !rs && (m_cnt == int'(TOPV));
            la  = hit(ld_a_edge, ra, fa) && !m_arm && !ht;
            lb  = hit(ld_b_edge, ra, fa) && m_arm && !ht;
            ovr = (la && m_pa && !rd_a) || (lb && m_pb && !rd_b);
            ev = {ext, lb, la, rch, 2'b00, ovr, ov};
            m_fl = (rd_status ? 8'h00 : m_fl) | ev;
            if (la) m_ca = m_cnt;
            if (lb) m_cb = m_cnt;
            if (rs) m_cnt = 0;
            else if (adv) m_cnt = (m_cnt + 1) % (1 << W);
            if (clk_dis_cmd || (lb && off_on_b)) m_run = 0;
            else if (clk_en_cmd) m_run = 1;
            if (ht) m_halt = 0;
            else if (lb && stop_on_b) m_halt = 1;
            m_pa = la || (m_pa && !rd_a);
            m_pb = lb || (m_pb && !rd_b);
            if (ht) m_arm = 0;
            else if (la) m_arm = 1;
            else if (lb) m_arm = 0;
            sa = {sa[1:0], pin_a};
            sb = {sb[1:0], pin_b};
        end
    end

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // compare on every clock, 2 ns after the edge
    always @(posedge clk) begin
        #2;
        if (!rst && !done) begin
            chk("R2", "count", count, m_cnt);
            chk("R3", "cap_a", cap_a, m_ca);
            chk("R4", "cap_b", cap_b, m_cb);
            chk("R10", "flags", status[7:0], m_fl);
            chk("R10", "zero bits", status[15:8], 0);
            chk("R5", "run state", status[16], m_run);
            chk("R11", "pin mirrors", status[18:17], {sb[1], sa[1]});
            chk("R11", "irq", irq, |(m_fl & irq_mask));
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_a(int hold);
        pin_a = 1'b1; step(hold);
        pin_a = 1'b0; step(hold);
    endtask

    initial begin
        step(3);
        // R1: reset state
        chk("R1", "count in reset", count, 0);
        chk("R1", "captures in reset", {cap_a, cap_b}, 0);
        chk("R1", "status in reset", status, 0);
        chk("R1", "irq in reset", irq, 0);
        rst = 1'b0;
        step(2);

        // R2: start, tick selection, stop priority
        clk_en_cmd = 1; step(1); clk_en_cmd = 0;
        step(20);
        clk_sel = 1'b1; step(15);
        clk_sel = 1'b0;
        clk_en_cmd = 1; clk_dis_cmd = 1; step(1);
        clk_en_cmd = 0; clk_dis_cmd = 0; step(5);
        clk_en_cmd = 1; step(1); clk_en_cmd = 0; step(5);

        // R3 R4: A on rising, B on falling, ordered captures
        ld_a_edge = 2'd1; ld_b_edge = 2'd2;
        pulse_a(6);
        rd_a = 1; rd_b = 1; step(1); rd_a = 0; rd_b = 0;
        pin_b = 1; step(4); pin_b = 0; step(4);   // pin B never loads
        // R9: loads without reads overrun
        pulse_a(5);
        pulse_a(5);
        rd_status = 1; step(1); rd_status = 0;
        rd_a = 1; rd_b = 1; step(1); rd_a = 0; rd_b = 0;
        // R3 R4: both edges, alternating A then B
        ld_a_edge = 2'd3; ld_b_edge = 2'd3;
        pulse_a(4); pulse_a(4);
        ld_a_edge = 2'd0;
        pulse_a(4);                                // no load at all

        // R5: freeze on B load, released by software trigger
        ld_a_edge = 2'd1; ld_b_edge = 2'd2; stop_on_b = 1;
        sw_trig = 1; step(1); sw_trig = 0;
        pulse_a(5);
        step(10);
        sw_trig = 1; step(1); sw_trig = 0; step(5);
        // R5: clock off on B load
        stop_on_b = 0; off_on_b = 1;
        pulse_a(5);
        step(6);
        off_on_b = 0;
        clk_en_cmd = 1; step(1); clk_en_cmd = 0; step(4);

        // R6: pin B rising trigger, then pin A falling trigger
        ld_a_edge = 2'd0; ld_b_edge = 2'd0;
        trg_edge = 2'd1; trg_from_a = 0;
        step(10);
        pin_b = 1; step(6); pin_b = 0; step(6);
        trg_edge = 2'd2; trg_from_a = 1;
        pulse_a(6);
        trg_edge = 2'd0;
        pulse_a(6);                                // no trigger
        // R6: trigger in the same cycle as a load event blocks the load
        ld_a_edge = 2'd1; trg_edge = 2'd1; trg_from_a = 1;
        pulse_a(6);
        trg_edge = 2'd0; ld_a_edge = 2'd0;

        // R7: compare restart
        rc_val = 8'd30; rc_restart_en = 1;
        step(80);
        // R10: status reads held while compare events keep arriving
        rd_status = 1; step(40); rd_status = 0;
        rc_restart_en = 0;

        // R8: natural wrap, with compare equal to all ones on a second pass
        step(300);
        rc_val = TOPV;
        step(260);

        // R11: masked interrupt
        irq_mask = 8'h01; step(3);
        irq_mask = 8'h10; step(3);
        irq_mask = 8'hFF; step(3);
        rd_status = 1; step(1); rd_status = 0;
        irq_mask = 8'h00; step(5);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule